// File: doc/BRIEF.md
# PCI Interrupt Line Router with Software SMI Trigger

The block takes register writes from a configuration bus and does two jobs. First, it routes the four PCI interrupt request lines (INTA to INTD) to a 16-bit ISA IRQ vector. Each line has a 4-bit route code, and a fixed, non-linear table turns the code into an IRQ number. Some codes in the table mean "not routed". Second, it watches the power-management control register for a software trigger edge. When it sees one, it raises SMI, NMI, IRQ15 or IRQ10, chosen by a select field in the SMI status register, and it marks the status register.

A small state machine handles the trigger. The states are:
- `TRG_IDLE` waits for a qualifying write. It moves to `TRG_FIRE` when that write arrives, and captures the action select at the same moment.
- `TRG_FIRE` lasts exactly one cycle. It applies the captured action, sets the status flags and returns to `TRG_IDLE`.

Once raised, the SMI, NMI and soft-IRQ outputs stay asserted until their acknowledge inputs clear them.

Top module: `intx_router`

## Requirements
- R1: Register 0x42 holds the route codes for INTA (bits 3:0) and INTB (bits 7:4). Register 0x43 holds the codes for INTC (bits 3:0) and INTD (bits 7:4). A new code takes effect on `irq_o` from the clock edge that captures the write.
- R2: Route codes 0 to 15 select IRQs 0, 3, 4, 7, 0, 0, 0, 0, 9, 10, 5, 6, 11, 12, 14 and 15 respectively. An asserted `intx_i[n]` drives `irq_o` bit IRQ, with no clock delay.
- R3: A code that selects IRQ 0 (codes 0, 4, 5, 6 and 7) leaves its line unrouted, so that line sets no `irq_o` bit.
- R4: When several asserted lines select the same IRQ, that `irq_o` bit is the logical OR of them.
- R5: A trigger happens only on a write to register 0x30 that meets all three conditions:
  - bit 4 of the new value is set;
  - bit 2 of the new value is set;
  - bit 3 goes from 0 (in the previously stored value) to 1.

  Any other write to 0x30 raises nothing.
- R6: On a trigger, status bits 5:4 (as they stand when the triggering write arrives) choose the action: 00 sets `smi_o`, 01 sets `nmi_o`, 10 sets `irq_o[15]` and 11 sets `irq_o[10]`. The output rises on the second clock edge after the write edge.
- R7: A trigger sets status bits 3:1, which are visible on `stat_o`. A write to register 0x35 updates only bits 7:4 and leaves bits 3:0 unchanged.
- R8: `smi_o` stays high until `ack_smi` is sampled. `nmi_o` stays high until `ack_nmi` is sampled. The two soft IRQ bits stay high until `ack_irq` is sampled.
- R9: After reset, all routes are disabled, `smi_o` and `nmi_o` are low, `irq_o` is zero and `stat_o` is zero.
- R10: Writes to any other address change no route, no status bit and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register index |
| wr_data | input | 8 | Register write data |
| intx_i | input | 4 | PCI INTA..INTD request levels, bit 0 = INTA |
| ack_smi | input | 1 | Clears the SMI output |
| ack_nmi | input | 1 | Clears the NMI output |
| ack_irq | input | 1 | Clears the soft IRQ15/IRQ10 latches |
| irq_o | output | 16 | ISA IRQ request vector |
| smi_o | output | 1 | SMI request level |
| nmi_o | output | 1 | NMI request level |
| stat_o | output | 8 | SMI status register |

## Verification
The bench builds the block with its default parameters: four lines, 4-bit codes and a 16-bit IRQ vector. At this size, every code on every line can be swept with the request line idle, alone and together with the others, so the whole route table and all its disabled holes are compared against a table written out in the bench. All four trigger actions are fired in turn, and the writes that must not fire (a missing bit 4, a missing bit 2, bit 3 already set) are placed between them, where any extra event would show on the outputs.

// File: rtl/intx_rt_pkg.sv
package intx_rt_pkg;

    typedef enum logic [0:0] {
        TRG_IDLE = 1'b0,
        TRG_FIRE = 1'b1
    } trg_state_t;

    typedef enum logic [1:0] {
        ACT_SMI   = 2'd0,
        ACT_NMI   = 2'd1,
        ACT_IRQ15 = 2'd2,
        ACT_IRQ10 = 2'd3
    } trg_action_t;

    // Route code to IRQ number; 0 means the line is not routed.
    function automatic logic [3:0] code_to_irq(input logic [3:0] code);
        logic [3:0] irq;
        unique case (code)
            4'd1:    irq = 4'd3;
            4'd2:    irq = 4'd4;
            4'd3:    irq = 4'd7;
            4'd8:    irq = 4'd9;
            4'd9:    irq = 4'd10;
            4'd10:   irq = 4'd5;
            4'd11:   irq = 4'd6;
            4'd12:   irq = 4'd11;
            4'd13:   irq = 4'd12;
            4'd14:   irq = 4'd14;
            4'd15:   irq = 4'd15;
            default: irq = 4'd0;
        endcase
        return irq;
    endfunction

endpackage

// File: rtl/route_decode.sv
module route_decode
    import intx_rt_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int IRQ_W  = 16
) (
    input  logic [CODE_W-1:0] code,
    input  logic              req,
    output logic [IRQ_W-1:0]  mask
);
    localparam int IDX_W = $clog2(IRQ_W);

    logic [3:0] irq_num;

    always_comb begin
        irq_num = code_to_irq(code[3:0]);
        mask    = '0;
        if (req && (irq_num != 4'd0))
            mask[irq_num[IDX_W-1:0]] = 1'b1;
    end
endmodule

// File: rtl/trig_fsm.sv
module trig_fsm
    import intx_rt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire_req,
    input  logic [1:0] act_sel,
    input  logic       ack_smi,
    input  logic       ack_nmi,
    input  logic       ack_irq,
    output logic       smi_o,
    output logic       nmi_o,
    output logic       soft_irq15,
    output logic       soft_irq10,
    output logic       stat_set
);
    trg_state_t  st_q, st_d;
    trg_action_t sel_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= TRG_IDLE;
            sel_q <= ACT_SMI;
        end else begin
            st_q <= st_d;
            if (st_q == TRG_IDLE && fire_req)
                sel_q <= trg_action_t'(act_sel);
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TRG_IDLE: if (fire_req) st_d = TRG_FIRE;
            TRG_FIRE: st_d = TRG_IDLE;
            default:  st_d = TRG_IDLE;
        endcase
    end

    // Output latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smi_o      <= 1'b0;
            nmi_o      <= 1'b0;
            soft_irq15 <= 1'b0;
            soft_irq10 <= 1'b0;
        end else begin
            if (ack_smi) smi_o <= 1'b0;
            if (ack_nmi) nmi_o <= 1'b0;
            if (ack_irq) begin
                soft_irq15 <= 1'b0;
                soft_irq10 <= 1'b0;
            end
            if (st_q == TRG_FIRE) begin
                unique case (sel_q)
                    ACT_SMI:   smi_o      <= 1'b1;
                    ACT_NMI:   nmi_o      <= 1'b1;
                    ACT_IRQ15: soft_irq15 <= 1'b1;
                    ACT_IRQ10: soft_irq10 <= 1'b1;
                    default:   smi_o      <= 1'b1;
                endcase
            end
        end
    end

    assign stat_set = (st_q == TRG_FIRE);

    // R5
    fire_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == TRG_FIRE |=> st_q == TRG_IDLE);

    // R6
    fire_smi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TRG_FIRE && sel_q == ACT_SMI) |=> smi_o);

    // R8
    smi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_o && !ack_smi) |=> smi_o);

    // R8
    nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_o && !ack_nmi) |=> nmi_o);
endmodule

// File: rtl/intx_router.sv
module intx_router
    import intx_rt_pkg::*;
#(
    parameter int          NUM_INTX   = 4,
    parameter int          CODE_W     = 4,
    parameter int          IRQ_W      = 16,
    parameter int          ADDR_W     = 8,
    parameter int          DATA_W     = 8,
    parameter int          SOFT_IRQ_A = 15,
    parameter int          SOFT_IRQ_B = 10,
    parameter logic [7:0]  ROUTE_BASE = 8'h42,
    parameter logic [7:0]  PMU_ADDR   = 8'h30,
    parameter logic [7:0]  STAT_ADDR  = 8'h35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NUM_INTX-1:0] intx_i,
    input  logic              ack_smi,
    input  logic              ack_nmi,
    input  logic              ack_irq,
    output logic [IRQ_W-1:0]  irq_o,
    output logic              smi_o,
    output logic              nmi_o,
    output logic [DATA_W-1:0] stat_o
);
    localparam int PER_REG = DATA_W / CODE_W;

    logic [CODE_W-1:0] route_q [NUM_INTX];
    logic [DATA_W-1:0] pmu_q;
    logic [DATA_W-1:0] stat_q;
    logic              fire_req;
    logic              stat_set;
    logic              soft_a, soft_b;
    logic [IRQ_W-1:0]  line_mask [NUM_INTX];

    assign fire_req = wr_en && (wr_addr == PMU_ADDR[ADDR_W-1:0])
                   && wr_data[4] && wr_data[2] && wr_data[3] && !pmu_q[3];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < NUM_INTX; l++) route_q[l] <= '0;
            pmu_q  <= '0;
            stat_q <= '0;
        end else begin
            if (wr_en) begin
                for (int l = 0; l < NUM_INTX; l++)
                    if (wr_addr == ADDR_W'(ROUTE_BASE + l / PER_REG))
                        route_q[l] <= wr_data[(l % PER_REG)*CODE_W +: CODE_W];
                if (wr_addr == PMU_ADDR[ADDR_W-1:0])
                    pmu_q <= wr_data;
                if (wr_addr == STAT_ADDR[ADDR_W-1:0])
                    stat_q[7:4] <= wr_data[7:4];
            end
            if (stat_set)
                stat_q[3:1] <= 3'b111;
        end
    end

    trig_fsm u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire_req  (fire_req),
        .act_sel   (stat_q[5:4]),
        .ack_smi   (ack_smi),
        .ack_nmi   (ack_nmi),
        .ack_irq   (ack_irq),
        .smi_o     (smi_o),
        .nmi_o     (nmi_o),
        .soft_irq15(soft_a),
        .soft_irq10(soft_b),
        .stat_set  (stat_set)
    );

    for (genvar g = 0; g < NUM_INTX; g++) begin : g_line
        route_decode #(.CODE_W(CODE_W), .IRQ_W(IRQ_W)) u_dec (
            .code(route_q[g]),
            .req (intx_i[g]),
            .mask(line_mask[g])
        );
    end

    always_comb begin
        irq_o = '0;
        for (int l = 0; l < NUM_INTX; l++) irq_o = irq_o | line_mask[l];
        irq_o[SOFT_IRQ_A] = irq_o[SOFT_IRQ_A] | soft_a;
        irq_o[SOFT_IRQ_B] = irq_o[SOFT_IRQ_B] | soft_b;
    end

    assign stat_o = stat_q;

    // R7
    stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[2] |=> stat_q[2]);

    // R7
    stat_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_set |=> stat_q[3:1] == 3'b111);

    // R3
    irq0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o[0]);
endmodule

// File: tb/sim_intx_router.sv
module sim_intx_router;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [3:0]  intx_i = '0;
    logic        ack_smi = 1'b0, ack_nmi = 1'b0, ack_irq = 1'b0;
    logic [15:0] irq_o;
    logic        smi_o, nmi_o;
    logic [7:0]  stat_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intx_router u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .intx_i(intx_i), .ack_smi(ack_smi),
        .ack_nmi(ack_nmi), .ack_irq(ack_irq), .irq_o(irq_o),
        .smi_o(smi_o), .nmi_o(nmi_o), .stat_o(stat_o)
    );

    function automatic int exp_irq(input int code);
        case (code)
            1: return 3;   2: return 4;   3: return 7;
            8: return 9;   9: return 10;  10: return 5;
            11: return 6;  12: return 11; 13: return 12;
            14: return 14; 15: return 15;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_ack(input int which);
        @(negedge clk);
        ack_smi = (which == 0); ack_nmi = (which == 1); ack_irq = (which == 2);
        @(negedge clk);
        ack_smi = 1'b0; ack_nmi = 1'b0; ack_irq = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        intx_i = 4'hF;
        #1;
        check("R9 irq after reset", irq_o, 0);
        check("R9 smi/nmi after reset", {smi_o, nmi_o}, 0);
        check("R9 stat after reset", stat_o, 0);
        intx_i = 4'h0;

        // R1 R2 R3 exhaustive sweep
        for (int l = 0; l < 4; l++) begin
            for (int c = 0; c < 16; c++) begin
                logic [15:0] e;
                wr(8'h42, (l == 0) ? 8'(c) : (l == 1) ? 8'(c << 4) : 8'h00);
                wr(8'h43, (l == 2) ? 8'(c) : (l == 3) ? 8'(c << 4) : 8'h00);
                e = (exp_irq(c) != 0) ? 16'(1 << exp_irq(c)) : 16'h0;
                intx_i = 4'h0; #1;
                check("R1 idle line", irq_o, 0);
                intx_i = 4'(1 << l); #1;
                check((exp_irq(c) == 0) ? "R3 unrouted code" : "R2 code table", irq_o, e);
                intx_i = 4'hF; #1;
                check("R1 only own line routed", irq_o, e);
                intx_i = 4'h0;
            end
        end

        // R4 shared IRQ
        wr(8'h42, 8'hCC); wr(8'h43, 8'hCC);
        intx_i = 4'b0101; #1;
        check("R4 OR of shared lines", irq_o, 16'h0800);
        intx_i = 4'b1000; #1;
        check("R4 single line on shared IRQ", irq_o, 16'h0800);
        intx_i = 4'h0;
        wr(8'h42, 8'h00); wr(8'h43, 8'h00);

        // R10 other address ignored
        wr(8'h44, 8'hFF); wr(8'h31, 8'h1C);
        intx_i = 4'hF; #1;
        check("R10 foreign write no route", irq_o, 0);
        intx_i = 4'h0;
        @(negedge clk);
        check("R10 foreign write no event", {smi_o, nmi_o, stat_o}, 0);

        // R5 non-qualifying writes
        wr(8'h30, 8'h0C); @(negedge clk);
        check("R5 no bit4 no fire", {smi_o, nmi_o, irq_o, stat_o}, 0);
        wr(8'h30, 8'h00);
        wr(8'h30, 8'h18); @(negedge clk);
        check("R5 no bit2 no fire", {smi_o, nmi_o, irq_o, stat_o}, 0);

        // R6 each action, R7 status, R8 hold and ack
        for (int s = 0; s < 4; s++) begin
            logic [15:0] ei;
            wr(8'h35, 8'(s << 4));
            wr(8'h30, 8'h00);
            wr(8'h30, 8'h1C);
            #1;
            check("R6 no output before second edge", {smi_o, nmi_o, irq_o}, 0);
            @(negedge clk);
            ei = (s == 2) ? 16'h8000 : (s == 3) ? 16'h0400 : 16'h0;
            check("R6 action select", {smi_o, nmi_o, irq_o}, {(s == 0), (s == 1), ei});
            check("R7 status bits set", stat_o, 8'((s << 4) | 8'h0E));
            repeat (3) @(negedge clk);
            check("R8 held until ack", {smi_o, nmi_o, irq_o}, {(s == 0), (s == 1), ei});
            // R5 bit3 already set: no second fire
            wr(8'h30, 8'h1C); @(negedge clk);
            pulse_ack((s == 0) ? 0 : (s == 1) ? 1 : 2);
            check("R8 cleared by ack", {smi_o, nmi_o, irq_o}, 0);
            @(negedge clk);
            check("R5 bit3 already set no refire", {smi_o, nmi_o, irq_o}, 0);
        end

        // R8 wrong ack does not clear
        wr(8'h35, 8'h00); wr(8'h30, 8'h00); wr(8'h30, 8'h1C); @(negedge clk);
        pulse_ack(1);
        check("R8 nmi ack leaves smi", smi_o, 1'b1);
        pulse_ack(0);
        check("R8 smi ack clears", smi_o, 1'b0);

        // R7 status write keeps low nibble
        wr(8'h35, 8'hA1);
        check("R7 status low nibble kept", stat_o, 8'hAE);

        finish_run();
    end
endmodule